// File: doc/BRIEF.md
# I2C Command Line Sequencer

This block sits behind a character source, such as a serial receiver, and collects one line of ASCII command text. When a carriage return (0x0D) or line feed (0x0A) closes the line, the block checks the whole line for syntax errors. Only if the line is clean does it walk it again from the left and turn each token into an I2C master operation. Opening and closing square brackets give bus START and STOP. A token such as `0x3C` writes a byte. The token `r` reads one byte, and `r:N` reads N bytes in a row.

Operations go one at a time to a separate bit-level engine over a request/done handshake. The engine returns read data and the write acknowledge bit. Each write and each read puts one byte on an output stream. The sequencer itself decides, read by read, whether the master acknowledges. Both the character input and the result output are valid/ready streams. The input drops `in_ready` for as long as a line is being checked or executed. The output holds its byte until `out_ready` is seen, and no further bus operation starts meanwhile, so a slow consumer stalls the bus sequence instead of losing data.

Top module: `i2c_script_seq`

## Requirements
- R1: A character is taken when `in_valid` and `in_ready` are both high. Nothing reaches the bus before a terminator (0x0D or 0x0A) closes a non-empty line. `in_ready` stays low from that terminator until the line has been fully processed.
- R2: `[` issues a START operation (`op_code` 0) and `]` issues a STOP operation (`op_code` 1).
- R3: `0` followed by `x` or `X` and then one or two hex digits (either letter case) issues a WRITE (`op_code` 2) with that value on `op_wdata`. The result byte is 0x00 when the target acknowledged (`op_nack` low) and 0x01 when it did not.
- R4: `r` or `R` alone issues one READ (`op_code` 3). `r:N`, with N written as 1 to 3 decimal digits and worth 1 to 255, issues N READs. Each read returns its `op_rdata` byte on the output stream.
- R5: `op_ack` is 1 on every READ except the final read of a read token whose next non-space character is `]`. That final read gets 0. Reads at the end of a line with no `]` all get 1.
- R6: Operations are issued strictly left to right. For example, `[0x31 r:5]` gives START, WRITE 0x31, five READs, STOP.
- R7: Spaces separate tokens and have no other effect.
- R8: Any other character, an `x` or hex digit missing after `0`, or a count that is empty, zero or above 255 sets `syn_err`. In that case the line issues no operation at all. `syn_err` stays set until the first character of the next line is taken.
- R9: A line holds at most 255 characters. Further characters are dropped and set `ovf`. An overflowed line is discarded at its terminator without bus activity. `ovf` stays set until the first character of the next line is taken.
- R10: `op_valid` holds, with `op_code`, `op_wdata` and `op_ack` unchanged, until `op_done` is seen. The next operation is issued only after that.
- R11: `out_valid` holds with `out_data` unchanged until `out_ready` is seen. No operation is requested while a result byte is pending.
- R12: After reset `in_ready` is 1, while `op_valid`, `out_valid`, `syn_err` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character available |
| in_data | input | 8 | ASCII character |
| in_ready | output | 1 | Sequencer accepts a character |
| op_valid | output | 1 | Bus operation requested |
| op_code | output | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| op_wdata | output | 8 | Byte to write |
| op_ack | output | 1 | For READ: 1 master acknowledges, 0 not |
| op_done | input | 1 | Engine finished the operation (one-cycle pulse) |
| op_rdata | input | 8 | Byte read, valid with `op_done` |
| op_nack | input | 1 | Write was not acknowledged, valid with `op_done` |
| out_valid | output | 1 | Result byte available |
| out_data | output | 8 | Read byte or write acknowledge code |
| out_ready | input | 1 | Consumer takes the result byte |
| syn_err | output | 1 | Last line had a syntax error |
| ovf | output | 1 | Characters were dropped on the current or last line |

## Verification
On every cycle, the assertions check the handshake rules: held requests and results, no request while a result is pending, no request while `syn_err` is set, and `ovf` rising only when the buffer was full and `in_ready` being low during requests. The parsing itself can only be shown by the bench scenarios. These cover the order of operations, hex and count decoding, the choice between acknowledge and no-acknowledge on the last read, and the discarding of bad and overlong lines. Each scenario compares the full logged operation and result streams against a list built from the requirements.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_SP    = 8'h20;
  localparam logic [7:0] CH_LB    = 8'h5B;
  localparam logic [7:0] CH_RB    = 8'h5D;
  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_LX    = 8'h78;
  localparam logic [7:0] CH_UX    = 8'h58;
  localparam logic [7:0] CH_LR    = 8'h72;
  localparam logic [7:0] CH_UR    = 8'h52;
  localparam logic [7:0] CH_COLON = 8'h3A;
endpackage

// File: rtl/isq_linebuf.sv
module isq_linebuf #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic          release_i,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_char,
  output logic [AW-1:0] len,
  output logic          line_go,
  output logic          line_start,
  output logic          ovf
);
  import isq_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MAXLEN = AW'(DEPTH - 1);

  logic [7:0] mem [DEPTH];
  logic       busy;
  logic       accept, term;

  assign in_ready   = !busy;
  assign accept     = in_valid && !busy;
  assign term       = (in_data == CH_CR) || (in_data == CH_LF);
  assign line_go    = accept && term && (len != '0) && !ovf;
  assign line_start = accept && !term && (len == '0);
  assign rd_char    = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (accept && !term && len != MAXLEN) mem[len] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      len  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (release_i) begin
        busy <= 1'b0;
        len  <= '0;
      end
      if (accept) begin
        if (term) begin
          if (line_go) busy <= 1'b1;
          else         len  <= '0;
        end else begin
          if (line_start) ovf <= 1'b0;
          if (len == MAXLEN) ovf <= 1'b1;
          else               len <= len + 1'b1;
        end
      end
    end
  end

  a_r9_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(len) == MAXLEN) && $past(in_valid));
endmodule

// File: rtl/isq_charclass.sv
module isq_charclass (
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] hex_val,
  output logic       is_dec,
  output logic [3:0] dec_val
);
  always_comb begin
    is_dec  = (ch >= 8'h30) && (ch <= 8'h39);
    dec_val = ch[3:0];
    is_hex  = 1'b0;
    hex_val = 4'h0;
    if (is_dec) begin
      is_hex  = 1'b1;
      hex_val = ch[3:0];
    end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
      is_hex  = 1'b1;
      hex_val = ch[3:0] + 4'd9;
    end
  end
endmodule

// File: rtl/isq_exec.sv
module isq_exec #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_go,
  input  logic          line_start,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] rd_idx,
  input  logic [7:0]    ch,
  input  logic          is_hex,
  input  logic [3:0]    hex_val,
  input  logic          is_dec,
  input  logic [3:0]    dec_val,
  output logic          release_o,
  output logic          op_valid,
  output logic [1:0]    op_code,
  output logic [7:0]    op_wdata,
  output logic          op_ack,
  input  logic          op_done,
  input  logic [7:0]    op_rdata,
  input  logic          op_nack,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          syn_err
);
  import isq_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_HX, S_H1, S_H2, S_RD, S_CNT, S_FLUSH, S_OP, S_OUT
  } st_e;

  st_e          st;
  logic         exec_pass;
  logic [AW-1:0] idx;
  logic [7:0]   wbyte;
  logic [9:0]   cnt;
  logic [1:0]   ndig;
  logic [7:0]   rd_pend;
  logic         nack_last;
  op_e          op_q;
  logic         ack_q;
  logic [7:0]   out_q;
  logic         err_q;

  logic at_end, dig_ok, err, tok_ok, finish;
  logic [7:0] wnext;
  logic [9:0] cnt_next;

  assign rd_idx    = idx;
  assign at_end    = (idx == len);
  assign dig_ok    = !at_end && is_dec && (ndig != 2'd3);
  assign cnt_next  = {cnt[6:0], 3'b000} + {cnt[8:0], 1'b0} + {6'd0, dec_val};
  assign wnext     = (!at_end && is_hex) ? {wbyte[3:0], hex_val} : wbyte;
  assign tok_ok    = (ch == CH_SP) || (ch == CH_LB) || (ch == CH_RB) || (ch == CH_ZERO)
                     || (ch == CH_LR) || (ch == CH_UR);
  assign finish    = (st == S_SCAN) && at_end && (rd_pend == 8'd0) && exec_pass;
  assign release_o = finish || err;

  always_comb begin
    err = 1'b0;
    case (st)
      S_SCAN:  err = !at_end && (rd_pend == 8'd0) && !tok_ok;
      S_HX:    err = at_end || !((ch == CH_LX) || (ch == CH_UX));
      S_H1:    err = at_end || !is_hex;
      S_CNT:   err = !dig_ok && ((ndig == 2'd0) || (cnt == 10'd0) || (cnt > 10'd255));
      default: err = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; exec_pass <= 1'b0; idx <= '0; wbyte <= '0; cnt <= '0; ndig <= '0;
      rd_pend <= '0; nack_last <= 1'b0; op_q <= OP_START; ack_q <= 1'b0; out_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (line_start) err_q <= 1'b0;
      if (err) begin
        err_q <= 1'b1;
        st    <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (line_go) begin
            exec_pass <= 1'b0; idx <= '0; rd_pend <= '0; st <= S_SCAN;
          end
          S_SCAN: begin
            if (at_end) begin
              if (rd_pend != 8'd0) begin nack_last <= 1'b0; st <= S_FLUSH; end
              else if (!exec_pass) begin exec_pass <= 1'b1; idx <= '0; end
              else st <= S_IDLE;
            end else if (ch == CH_SP) begin
              idx <= idx + 1'b1;
            end else if (rd_pend != 8'd0) begin
              nack_last <= (ch == CH_RB);
              st        <= S_FLUSH;
            end else if (ch == CH_LB || ch == CH_RB) begin
              idx <= idx + 1'b1;
              if (exec_pass) begin
                op_q  <= (ch == CH_LB) ? OP_START : OP_STOP;
                ack_q <= 1'b0;
                st    <= S_OP;
              end
            end else if (ch == CH_ZERO) begin
              idx <= idx + 1'b1; st <= S_HX;
            end else begin
              idx <= idx + 1'b1; st <= S_RD;
            end
          end
          S_HX: begin idx <= idx + 1'b1; st <= S_H1; end
          S_H1: begin wbyte <= {4'h0, hex_val}; idx <= idx + 1'b1; st <= S_H2; end
          S_H2: begin
            wbyte <= wnext;
            if (!at_end && is_hex) idx <= idx + 1'b1;
            if (exec_pass) begin op_q <= OP_WRITE; ack_q <= 1'b0; st <= S_OP; end
            else st <= S_SCAN;
          end
          S_RD: begin
            if (!at_end && ch == CH_COLON) begin
              idx <= idx + 1'b1; cnt <= '0; ndig <= '0; st <= S_CNT;
            end else begin
              rd_pend <= 8'd1; st <= S_SCAN;
            end
          end
          S_CNT: begin
            if (dig_ok) begin
              cnt <= cnt_next; ndig <= ndig + 1'b1; idx <= idx + 1'b1;
            end else begin
              rd_pend <= cnt[7:0]; st <= S_SCAN;
            end
          end
          S_FLUSH: begin
            if (exec_pass) begin
              op_q    <= OP_READ;
              ack_q   <= !((rd_pend == 8'd1) && nack_last);
              rd_pend <= rd_pend - 1'b1;
              st      <= S_OP;
            end else begin
              rd_pend <= '0; st <= S_SCAN;
            end
          end
          S_OP: if (op_done) begin
            if (op_q == OP_WRITE)     begin out_q <= {7'd0, op_nack}; st <= S_OUT; end
            else if (op_q == OP_READ) begin out_q <= op_rdata;        st <= S_OUT; end
            else st <= S_SCAN;
          end
          S_OUT: if (out_ready) st <= (rd_pend != 8'd0) ? S_FLUSH : S_SCAN;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign op_valid  = (st == S_OP);
  assign op_code   = op_q;
  assign op_wdata  = wbyte;
  assign op_ack    = ack_q;
  assign out_valid = (st == S_OUT);
  assign out_data  = out_q;
  assign syn_err   = err_q;

  a_r10_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_done |=> op_valid && $stable(op_code) && $stable(op_wdata) && $stable(op_ack));
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r11_no_op_while_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !op_valid);
  a_r8_no_op_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    syn_err |-> !op_valid);
endmodule

// File: rtl/i2c_script_seq.sv
module i2c_script_seq #(
  parameter int LINE_AW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       op_valid,
  output logic [1:0] op_code,
  output logic [7:0] op_wdata,
  output logic       op_ack,
  input  logic       op_done,
  input  logic [7:0] op_rdata,
  input  logic       op_nack,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       syn_err,
  output logic       ovf
);
  logic [LINE_AW-1:0] len, rd_idx;
  logic [7:0] ch;
  logic       line_go, line_start, rel;
  logic       is_hex, is_dec;
  logic [3:0] hex_val, dec_val;

  isq_linebuf #(.AW(LINE_AW)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .release_i(rel), .rd_idx(rd_idx), .rd_char(ch), .len(len),
    .line_go(line_go), .line_start(line_start), .ovf(ovf)
  );

  isq_charclass u_cls (
    .ch(ch), .is_hex(is_hex), .hex_val(hex_val), .is_dec(is_dec), .dec_val(dec_val)
  );

  isq_exec #(.AW(LINE_AW)) u_exec (
    .clk(clk), .rst_n(rst_n), .line_go(line_go), .line_start(line_start), .len(len),
    .rd_idx(rd_idx), .ch(ch), .is_hex(is_hex), .hex_val(hex_val), .is_dec(is_dec),
    .dec_val(dec_val), .release_o(rel), .op_valid(op_valid), .op_code(op_code),
    .op_wdata(op_wdata), .op_ack(op_ack), .op_done(op_done), .op_rdata(op_rdata),
    .op_nack(op_nack), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .syn_err(syn_err)
  );

  a_r1_busy_during_ops: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !in_ready);
endmodule

// File: tb/i2c_script_seq_tb.sv
module i2c_script_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, op_valid, op_ack, out_valid, syn_err, ovf;
  logic [1:0] op_code;
  logic [7:0] op_wdata, out_data;
  logic op_done;
  logic [7:0] op_rdata;
  logic op_nack;
  logic out_ready = 1'b1;

  always #10 clk = ~clk;

  i2c_script_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata), .op_ack(op_ack),
    .op_done(op_done), .op_rdata(op_rdata), .op_nack(op_nack),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .syn_err(syn_err), .ovf(ovf)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bit engine model and loggers
  logic [10:0] op_log [0:1023];
  logic [7:0]  out_log [0:1023];
  int n_ops = 0;
  int n_outs = 0;
  int dly = 0;
  logic [7:0] rseq = 8'h40;

  always @(posedge clk) begin
    if (!rst_n) begin
      op_done <= 1'b0; op_rdata <= 8'h00; op_nack <= 1'b0; dly <= 0;
    end else begin
      op_done <= 1'b0;
      if (op_valid && !op_done) begin
        if (dly == 2) begin
          op_done <= 1'b1; dly <= 0;
          op_nack <= (op_code == 2'd2) && (op_wdata == 8'hEE);
          if (op_code == 2'd3) begin op_rdata <= rseq; rseq <= rseq + 8'd1; end
        end else dly <= dly + 1;
      end
      if (op_valid && op_done) begin
        op_log[n_ops] <= {op_code, (op_code == 2'd3) ? op_ack : 1'b0,
                          (op_code == 2'd2) ? op_wdata : 8'h00};
        n_ops <= n_ops + 1;
      end
      if (out_valid && out_ready) begin
        out_log[n_outs] <= out_data;
        n_outs <= n_outs + 1;
      end
    end
  end

  // expectations
  logic [10:0] e_op [0:1023];
  logic [7:0]  e_out [0:1023];
  int e_nop, e_nout, ob, oo;
  logic [7:0] e_rseq = 8'h40;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_begin();
    e_nop = 0; e_nout = 0; ob = n_ops; oo = n_outs;
  endtask
  task automatic e_start(); e_op[e_nop] = {2'd0, 1'b0, 8'h00}; e_nop++; endtask
  task automatic e_stop();  e_op[e_nop] = {2'd1, 1'b0, 8'h00}; e_nop++; endtask
  task automatic e_wr(input logic [7:0] b);
    e_op[e_nop] = {2'd2, 1'b0, b}; e_nop++;
    e_out[e_nout] = (b == 8'hEE) ? 8'h01 : 8'h00; e_nout++;
  endtask
  task automatic e_rd(input logic ack);
    e_op[e_nop] = {2'd3, ack, 8'h00}; e_nop++;
    e_out[e_nout] = e_rseq; e_nout++; e_rseq = e_rseq + 8'd1;
  endtask

  task automatic compare(input string req);
    check({req, " op count"}, n_ops - ob, e_nop);
    check({req, " out count"}, n_outs - oo, e_nout);
    for (int i = 0; i < e_nop && (ob + i) < n_ops; i++)
      check({req, " op entry"}, int'(op_log[ob + i]), int'(e_op[i]));
    for (int i = 0; i < e_nout && (oo + i) < n_outs; i++)
      check({req, " out byte"}, int'(out_log[oo + i]), int'(e_out[i]));
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_text(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_line(input string s);
    send_text(s); send_char(8'h0D); wait_idle();
  endtask

  // scenarios
  task automatic t_reset();
    check("R12 in_ready", in_ready, 1); check("R12 op_valid", op_valid, 0);
    check("R12 out_valid", out_valid, 0); check("R12 syn_err", syn_err, 0);
    check("R12 ovf", ovf, 0);
  endtask

  task automatic t_example();
    exp_begin();
    send_text("[0x31 r:5]");
    repeat (5) @(negedge clk);
    check("R1 no ops before terminator", n_ops - ob, 0);
    send_char(8'h0D);
    check("R1 in_ready low while busy", in_ready, 0);
    wait_idle();
    e_start(); e_wr(8'h31); e_rd(1); e_rd(1); e_rd(1); e_rd(1); e_rd(0); e_stop();
    compare("R6 R2 R4 R5 example");
  endtask

  task automatic t_case_hex();
    exp_begin();
    run_line("  [0X7   0xaB R ] ");
    e_start(); e_wr(8'h07); e_wr(8'hAB); e_rd(0); e_stop();
    compare("R3 R7 hex and case");
  endtask

  task automatic t_nack_and_open_reads();
    exp_begin();
    run_line("[0xEE r:2 0x0F r");
    e_start(); e_wr(8'hEE); e_rd(1); e_rd(1); e_wr(8'h0F); e_rd(1);
    compare("R5 R3 ack choice and write nack");
  endtask

  task automatic t_errors();
    string bad [4];
    bad[0] = "[0x12 q]"; bad[1] = "[r:0]"; bad[2] = "[r:256]"; bad[3] = "[0xg]";
    for (int k = 0; k < 4; k++) begin
      exp_begin();
      run_line(bad[k]);
      check("R8 syn_err set", syn_err, 1);
      compare("R8 no bus activity");
      send_char(8'h5B);
      check("R8 syn_err cleared by next line", syn_err, 0);
      send_char(8'h0A); wait_idle();
      e_start();
      compare("R8 recovery line");
    end
  endtask

  task automatic t_overflow();
    exp_begin();
    send_char(8'h5B);
    for (int i = 0; i < 253; i++) send_char(8'h20);
    send_char(8'h5D);
    check("R9 no ovf at 255", ovf, 0);
    send_char(8'h0D); wait_idle();
    e_start(); e_stop();
    compare("R9 full 255-char line runs");
    exp_begin();
    send_char(8'h5B);
    for (int i = 0; i < 254; i++) send_char(8'h20);
    check("R9 no ovf before limit", ovf, 0);
    send_char(8'h5D);
    check("R9 ovf on 256th char", ovf, 1);
    send_char(8'h0D); wait_idle();
    compare("R9 overflowed line discarded");
    check("R9 ovf held after discard", ovf, 1);
    send_char(8'h20);
    check("R9 ovf cleared by next line", ovf, 0);
    send_char(8'h0D); wait_idle();
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    exp_begin();
    out_ready = 1'b0;
    send_text("[0x21 0x22]"); send_char(8'h0D);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    held = out_data;
    repeat (10) @(negedge clk);
    check("R11 out_valid held", out_valid, 1);
    check("R11 out_data stable", out_data, held);
    check("R11 no op while pending", op_valid, 0);
    check("R10 one op so far past start", n_ops - ob, 2);
    out_ready = 1'b1;
    wait_idle();
    e_start(); e_wr(8'h21); e_wr(8'h22); e_stop();
    compare("R10 R11 stalled sequence");
  endtask

  task automatic t_long_read();
    exp_begin();
    run_line("[r:255]");
    e_start();
    for (int i = 0; i < 254; i++) e_rd(1);
    e_rd(0); e_stop();
    compare("R4 maximum count");
  endtask

  task automatic t_blank();
    exp_begin();
    run_line("    ");
    compare("R7 blank line");
    check("R7 no error on blank", syn_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_example();
    t_case_hex();
    t_nack_and_open_reads();
    t_errors();
    t_overflow();
    t_backpressure();
    t_long_read();
    t_blank();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule